// File: doc/BRIEF.md
# Reference-Counted Reset Channel Controller

This block drives a bank of reset lines, one for each downstream peripheral. Several clients may share one peripheral, so every channel keeps a usage counter: a release request raises it and a reset request lowers it. The physical line moves only when the first client releases the peripheral and again when the last one puts it back into reset. Any other request changes the counter and leaves the line as it is.

Requests come in one at a time over a valid/ready handshake. Each request names a channel and a direction. One configuration input sets the polarity of the whole bank. A second one turns on a mode in which the block waits after each line change until that channel's acknowledge input, passed through a two-flop synchronizer, reports the new level. The wait is bounded by a prescaled tick counter. Each finished request raises a one-cycle `done` pulse and sets a two-bit result code: 0 for success, 1 for an out-of-range channel, 2 for a reset request that found the counter already at zero, and 3 for an acknowledge timeout.

Top module: `refcnt_reset_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every counter is cleared and every line goes to its reset level. That level is 1 when `cfg_active_low` is 0 and 0 when it is 1. After reset `req_ready` is 1, and `busy` and `done` are 0.
- R2: A request whose `req_chan` is NUM_CH or higher completes with result code 1. It changes no line and no counter.
- R3: A release request (`req_assert`=0) increments the channel counter. It drives the line to the release level only when the counter was 0; a later release completes with code 0 and no line change.
- R4: A reset request (`req_assert`=1) on a nonzero counter decrements it. It drives the line to the reset level only when the counter goes from 1 to 0.
- R5: A reset request on a counter already at 0 completes with code 2 and still drives the line to its reset level. The counter stays at 0.
- R6: The level written to a line equals `req_assert` when `cfg_active_low` is 0, and its inverse when it is 1.
- R7: With `cfg_ack_mode`=0, every request completes one cycle after acceptance: `done` is high in that cycle for exactly one cycle, and `req_ready` stays high.
- R8: With `cfg_ack_mode`=1, a request that changes a line holds `busy`=1 and `req_ready`=0 until the synchronized acknowledge bit of that channel equals the written level. It then completes with the pending code, three cycles after the acknowledge input changes.
- R9: If the acknowledge does not match within ACK_LIMIT ticks of TICK_DIV cycles, the request completes with code 3. This happens ACK_LIMIT*TICK_DIV+1 cycles after acceptance. The line keeps its written level.
- R10: A counter saturates at 2^CNT_W-1: further release requests leave it there and do not wrap it.
- R11: With `cfg_ack_mode`=1, a request that changes only a counter completes one cycle after acceptance, without a wait.
- R12: Lines change only in the cycle after a request is accepted. They never change while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_active_low | input | 1 | 1: a line at 0 holds its peripheral in reset |
| cfg_ack_mode | input | 1 | 1: wait for the acknowledge after each line change |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_assert | input | 1 | 1: put into reset, 0: release |
| req_chan | input | IDX_W | Channel index of the request |
| ack_in | input | NUM_CH | Per-channel acknowledge, asynchronous |
| rst_out | output | NUM_CH | Per-channel reset lines |
| busy | output | 1 | Acknowledge wait in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | Result of the last completed request |

## Verification
The bench releases a channel twice and resets it twice. A controller without reference counting would drop the line on the first reset request, and one that counted wrongly would never raise it again. It issues a reset request on a zero counter and then a release request. A counter that underflowed to its maximum would then swallow the release, and the line would stay in reset. It sends an out-of-range index whose low bits alias a live channel, pushes a two-bit counter past saturation, and measures the exact completion cycle of an acknowledged change and of a timeout. A wrapping counter, a decoder that truncates the index, or an off-by-one timer each shows up as a wrong line level or a wrong cycle count. A final reset under inverted polarity checks that counters were cleared and that every written level flips.

// File: rtl/rrc_pkg.sv
// Shared types of the reference-counted reset controller.
// Assumes: result codes are visible at the port as two-bit values.
package rrc_pkg;

    typedef enum logic [1:0] {
        RRC_OK          = 2'd0,
        RRC_ERR_RANGE   = 2'd1,
        RRC_ERR_BALANCE = 2'd2,
        RRC_ERR_TIMEOUT = 2'd3
    } rrc_err_e;

    typedef enum logic {
        RRC_ST_IDLE = 1'b0,
        RRC_ST_WAIT = 1'b1
    } rrc_state_e;

endpackage

// File: rtl/rrc_ack_sync.sv
// Two-flop synchronizer for the per-channel acknowledge inputs.
// Assumes: each acknowledge bit is a level that stays stable for several
// cycles; bits are synchronized independently of each other.
module rrc_ack_sync #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ack_async,
    output logic [NUM_CH-1:0] ack_sync
);

    logic [NUM_CH-1:0] stage1_q;
    logic [NUM_CH-1:0] stage2_q;

    // Two register stages, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= ack_async;
            stage2_q <= stage1_q;
        end
    end

    assign ack_sync = stage2_q;

endmodule

// File: rtl/rrc_count_bank.sv
// Per-channel saturating usage counters.
// Assumes: at most one channel is updated per cycle, selected by op_sel. The
// block reports whether the selected counter is 0 or 1 before the update.
module rrc_count_bank #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 8,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_en,
    input  logic            op_up,
    input  logic [CH_W-1:0] op_sel,
    output logic            sel_zero,
    output logic            sel_one
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_all [NUM_CH];
    logic [CNT_W-1:0] cnt_sel;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [CNT_W-1:0] cnt_r;
        logic             hit;

        assign hit = op_en && (op_sel == CH_W'(i));

        // Saturating up/down count for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_r <= '0;
            end else if (hit) begin
                if (op_up) begin
                    if (cnt_r != CNT_MAX) cnt_r <= cnt_r + CNT_ONE;
                end else if (cnt_r != '0) begin
                    cnt_r <= cnt_r - CNT_ONE;
                end
            end
        end

        assign cnt_all[i] = cnt_r;

        // R10: a full counter does not wrap on a further increment
        a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && op_up && cnt_r == CNT_MAX) |=> (cnt_r == CNT_MAX));

        // R5: a zero counter does not underflow on a decrement
        a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && !op_up && cnt_r == '0) |=> (cnt_r == '0));
    end

    // Pick the counter of the selected channel.
    always_comb begin
        cnt_sel = cnt_all[op_sel];
    end

    assign sel_zero = (cnt_sel == '0);
    assign sel_one  = (cnt_sel == CNT_ONE);

endmodule

// File: rtl/rrc_ack_timer.sv
// Bounded wait timer: a prescaler of TICK_DIV cycles feeds a tick counter
// that stops at ACK_LIMIT.
// Assumes: start clears the timer, and the timer counts only while run is high.
module rrc_ack_timer #(
    parameter int TICK_DIV  = 125,
    parameter int ACK_LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expired
);

    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int LIM_W = $clog2(ACK_LIMIT + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
    localparam logic [LIM_W-1:0] LIM_VAL  = LIM_W'(ACK_LIMIT);

    logic [DIV_W-1:0] pre_q;
    logic [LIM_W-1:0] ticks_q;

    assign expired = (ticks_q == LIM_VAL);

    // Prescaler and tick count; both stop once the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            pre_q   <= '0;
            ticks_q <= '0;
        end else if (run && !expired) begin
            if (pre_q == DIV_LAST) begin
                pre_q   <= '0;
                ticks_q <= ticks_q + LIM_W'(1);
            end else begin
                pre_q <= pre_q + DIV_W'(1);
            end
        end
    end

    // R9: once expired, the timer stays expired until restarted
    a_r9_expired_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !start) |=> expired);

endmodule

// File: rtl/refcnt_reset_ctrl.sv
// Reference-counted reset channel controller (top level).
// Accepts one request at a time, updates the usage counter of the channel,
// and writes the reset line only on the first release and on the last reset
// request. In acknowledge mode it waits for the synchronized acknowledge
// bit, bounded by a timer.
// Assumes: cfg_active_low is static while not in reset; NUM_CH >= 2 and
// IDX_W is large enough to hold NUM_CH.
module refcnt_reset_ctrl
    import rrc_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int IDX_W     = 4,
    parameter int CNT_W     = 8,
    parameter int TICK_DIV  = 125,
    parameter int ACK_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_active_low,
    input  logic              cfg_ack_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_assert,
    input  logic [IDX_W-1:0]  req_chan,
    input  logic [NUM_CH-1:0] ack_in,
    output logic [NUM_CH-1:0] rst_out,
    output logic              busy,
    output logic              done,
    output logic [1:0]        err_code
);

    localparam int               CH_W     = $clog2(NUM_CH);
    localparam logic [IDX_W:0]   NUM_CH_V = (IDX_W + 1)'(NUM_CH);

    rrc_state_e        state_q;
    rrc_err_e          err_q;
    rrc_err_e          pend_q;
    rrc_err_e          err_now;
    logic              done_q;
    logic [CH_W-1:0]   chan_q;
    logic              level_q;
    logic [NUM_CH-1:0] line_q;
    logic [NUM_CH-1:0] ack_s;

    logic            accept;
    logic            in_range;
    logic [CH_W-1:0] sel;
    logic            sel_zero;
    logic            sel_one;
    logic            drive_now;
    logic            level_now;
    logic            need_wait;
    logic            ack_match;
    logic            tmr_expired;

    assign req_ready = (state_q == RRC_ST_IDLE);
    assign busy      = (state_q == RRC_ST_WAIT);
    assign done      = done_q;
    assign err_code  = err_q;
    assign rst_out   = line_q;

    assign accept   = req_valid && req_ready;
    assign in_range = ({1'b0, req_chan} < NUM_CH_V);
    assign sel      = req_chan[CH_W-1:0];

    rrc_count_bank #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .CH_W   (CH_W)
    ) count_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_en    (accept && in_range),
        .op_up    (!req_assert),
        .op_sel   (sel),
        .sel_zero (sel_zero),
        .sel_one  (sel_one)
    );

    rrc_ack_sync #(
        .NUM_CH (NUM_CH)
    ) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_async (ack_in),
        .ack_sync  (ack_s)
    );

    rrc_ack_timer #(
        .TICK_DIV  (TICK_DIV),
        .ACK_LIMIT (ACK_LIMIT)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .run     (busy),
        .expired (tmr_expired)
    );

    // Decide whether the accepted request writes a line, and its result code.
    always_comb begin
        level_now = req_assert ^ cfg_active_low;
        drive_now = accept && in_range &&
                    (req_assert ? (sel_zero || sel_one) : sel_zero);
        need_wait = drive_now && cfg_ack_mode;
        if (!in_range)                  err_now = RRC_ERR_RANGE;
        else if (req_assert && sel_zero) err_now = RRC_ERR_BALANCE;
        else                             err_now = RRC_OK;
    end

    assign ack_match = (ack_s[chan_q] == level_q);

    // Reset-line register: all lines go to the reset level under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= {NUM_CH{~cfg_active_low}};
        end else if (drive_now) begin
            line_q[sel] <= level_now;
        end
    end

    // Request sequencing: immediate completion or a bounded acknowledge wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RRC_ST_IDLE;
            done_q  <= 1'b0;
            err_q   <= RRC_OK;
            pend_q  <= RRC_OK;
            chan_q  <= '0;
            level_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                RRC_ST_IDLE: begin
                    if (accept) begin
                        if (need_wait) begin
                            state_q <= RRC_ST_WAIT;
                            chan_q  <= sel;
                            level_q <= level_now;
                            pend_q  <= err_now;
                        end else begin
                            done_q <= 1'b1;
                            err_q  <= err_now;
                        end
                    end
                end
                RRC_ST_WAIT: begin
                    if (ack_match) begin
                        done_q  <= 1'b1;
                        err_q   <= pend_q;
                        state_q <= RRC_ST_IDLE;
                    end else if (tmr_expired) begin
                        done_q  <= 1'b1;
                        err_q   <= RRC_ERR_TIMEOUT;
                        state_q <= RRC_ST_IDLE;
                    end
                end
                default: state_q <= RRC_ST_IDLE;
            endcase
        end
    end

    // R2: an out-of-range request leaves every line untouched
    a_r2_range_no_line: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_range) |=> $stable(rst_out));

    // R3: a release on a nonzero counter leaves every line untouched
    a_r3_repeat_release_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_range && !req_assert && !sel_zero) |=> $stable(rst_out));

    // R12: no line moves while an acknowledge wait is in progress
    a_r12_wait_lines_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(rst_out));

    // R9: a timeout code is only produced at the end of a wait
    a_r9_timeout_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code == RRC_ERR_TIMEOUT) |-> $past(busy));

    // R8: no request is accepted while waiting
    a_r8_no_accept_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept);

endmodule

// File: tb/refcnt_reset_ctrl_tb_top.sv
// Directed bench for the reference-counted reset controller.
// One time unit is taken as 1 ns; the clock period is 8 units (125 MHz).
module refcnt_reset_ctrl_tb_top;

    localparam int NUM_CH    = 8;
    localparam int IDX_W     = 4;
    localparam int CNT_W     = 2;
    localparam int TICK_DIV  = 2;
    localparam int ACK_LIMIT = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_active_low = 1'b0;
    logic              cfg_ack_mode = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_assert = 1'b0;
    logic [IDX_W-1:0]  req_chan = '0;
    logic [NUM_CH-1:0] ack_in = '0;
    logic              req_ready;
    logic [NUM_CH-1:0] rst_out;
    logic              busy;
    logic              done;
    logic [1:0]        err_code;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    refcnt_reset_ctrl #(
        .NUM_CH    (NUM_CH),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W),
        .TICK_DIV  (TICK_DIV),
        .ACK_LIMIT (ACK_LIMIT)
    ) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_active_low (cfg_active_low),
        .cfg_ack_mode   (cfg_ack_mode),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_assert     (req_assert),
        .req_chan       (req_chan),
        .ack_in         (ack_in),
        .rst_out        (rst_out),
        .busy           (busy),
        .done           (done),
        .err_code       (err_code)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply reset with the given polarity; returns at a falling edge.
    task automatic do_reset(input logic al);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_active_low = al;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present one request; returns at the falling edge after acceptance.
    task automatic send(input logic a, input int ch);
        @(negedge clk);
        req_valid  = 1'b1;
        req_assert = a;
        req_chan   = IDX_W'(ch);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Count falling edges until done is seen (bounded).
    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset_state();
        do_reset(1'b0);
        chk("R1 lines after reset", int'(rst_out), 'hFF);
        chk("R1 ready after reset", int'(req_ready), 1);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 done after reset", int'(done), 0);
    endtask

    task automatic t_range();
        send(1'b0, 9);
        chk("R2 done on bad index", int'(done), 1);
        chk("R2 code on bad index", int'(err_code), 1);
        chk("R2 lines unchanged", int'(rst_out), 'hFF);
        // index 9 aliases channel 1 in its low bits: its counter must still be 0
        send(1'b0, 1);
        chk("R2 aliased counter untouched", int'(rst_out), 'hFD);
        chk("R2 aliased release code", int'(err_code), 0);
    endtask

    task automatic t_refcount();
        send(1'b0, 3);
        chk("R3 first release drives line", int'(rst_out), 'hF5);
        chk("R7 done after one cycle", int'(done), 1);
        chk("R7 ready stays high", int'(req_ready), 1);
        @(negedge clk);
        chk("R7 done lasts one cycle", int'(done), 0);
        send(1'b0, 3);
        chk("R3 second release no change", int'(rst_out), 'hF5);
        chk("R3 second release code", int'(err_code), 0);
        send(1'b1, 3);
        chk("R4 reset on count 2 no change", int'(rst_out), 'hF5);
        send(1'b1, 3);
        chk("R4 last reset drives line", int'(rst_out), 'hFD);
        chk("R6 active-high reset level is 1", int'(rst_out[3]), 1);
    endtask

    task automatic t_balance();
        send(1'b1, 4);
        chk("R5 balance code", int'(err_code), 2);
        chk("R5 line at reset level", int'(rst_out), 'hFD);
        send(1'b0, 4);
        chk("R5 counter stayed 0, release drives", int'(rst_out), 'hED);
        send(1'b1, 4);
        chk("R5 back to reset, code ok", int'(err_code), 0);
        chk("R5 line back to reset", int'(rst_out), 'hFD);
    endtask

    task automatic t_saturate();
        for (int k = 0; k < 4; k++) send(1'b0, 5);
        chk("R10 released after four", int'(rst_out), 'hDD);
        send(1'b1, 5);
        send(1'b1, 5);
        chk("R10 two resets keep line released", int'(rst_out), 'hDD);
        send(1'b1, 5);
        chk("R10 third reset drives (saturated at 3)", int'(rst_out), 'hFD);
        chk("R10 code ok", int'(err_code), 0);
    endtask

    task automatic t_ack_ok();
        int n;
        ack_in = 8'hFF;
        cfg_ack_mode = 1'b1;
        repeat (3) @(negedge clk);
        send(1'b0, 2);
        chk("R8 busy during wait", int'(busy), 1);
        chk("R8 ready low during wait", int'(req_ready), 0);
        chk("R8 line written before ack", int'(rst_out), 'hF9);
        ack_in[2] = 1'b0;
        wait_done(n);
        chk("R8 completion 3 cycles after ack", n, 3);
        chk("R8 code ok", int'(err_code), 0);
        @(negedge clk);
        chk("R8 ready back high", int'(req_ready), 1);
        chk("R8 busy back low", int'(busy), 0);
    endtask

    task automatic t_ack_skip();
        send(1'b0, 2);
        chk("R11 counter-only release completes at once", int'(done), 1);
        chk("R11 no wait", int'(busy), 0);
        chk("R11 lines unchanged", int'(rst_out), 'hF9);
        send(1'b1, 2);
        chk("R11 counter-only reset completes at once", int'(done), 1);
    endtask

    task automatic t_timeout();
        int n;
        send(1'b1, 2);
        chk("R9 line driven before wait", int'(rst_out), 'hFD);
        wait_done(n);
        chk("R9 timeout cycle count", n, ACK_LIMIT * TICK_DIV + 1);
        chk("R9 timeout code", int'(err_code), 3);
        chk("R9 line keeps level", int'(rst_out), 'hFD);
        cfg_ack_mode = 1'b0;
    endtask

    task automatic t_polarity();
        do_reset(1'b1);
        chk("R1 active-low reset level", int'(rst_out), 'h00);
        send(1'b0, 0);
        chk("R6 active-low release writes 1", int'(rst_out), 'h01);
        send(1'b0, 0);
        send(1'b1, 0);
        chk("R6 active-low count 2 to 1 no change", int'(rst_out), 'h01);
        send(1'b1, 0);
        chk("R6 active-low last reset writes 0", int'(rst_out), 'h00);
        send(1'b1, 1);
        chk("R1 counters cleared by reset", int'(err_code), 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_range();
        t_refcount();
        t_balance();
        t_saturate();
        t_ack_ok();
        t_ack_skip();
        t_timeout();
        t_polarity();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule